// File: doc/BRIEF.md
# Serial Audio Port Framer

This block drives the frame timing of a serial audio link toward an external signal processor. An enable input, `bit_tick`, paces it. Each tick advances the link by half a bit period. From these ticks the block produces the serial bit clock `ser_clk`, a frame sync pulse `ser_fsync` and the outgoing serial data `ser_dout`. On the same timing it collects incoming serial data from `ser_din` into parallel capture samples.

On the host side the block takes two 16-bit playback samples and five status flags: interrupt, capture enable, playback enable, and an overrange flag for each channel. It returns the left and right capture samples, each with a one-clock valid pulse. A 2-bit format select chooses the frame layout:

| Code | Layout |
|------|--------|
| 00 | Enhanced 64-bit frame with a status field |
| 01 | Same as 00 |
| 10 | Gapped frame: 32 clocked bits, then 32 bit periods with no clock |
| 11 | Split frame: playback slots first, capture slots second |

The controller has three states: `ST_SYNC`, `ST_FRONT` and `ST_BACK`.
- `ST_SYNC` covers the sync bit, which is bit period 63.
- `ST_FRONT` covers bits 0 to 31.
- `ST_BACK` covers bits 32 to 62.

Every transition happens on a falling tick:
- `ST_SYNC` goes to `ST_FRONT`. This is the frame start.
- `ST_FRONT` goes to `ST_BACK` after bit 31.
- `ST_BACK` goes to `ST_SYNC` after bit 62.

Top module: `sap_framer`

## Requirements
- R1: While reset is held and just after it is released, `ser_clk` is 0, `ser_fsync` is 1 (the lead-in sync bit), `ser_dout` is 0, both capture samples are 0 and both valid pulses are 0.
- R2: The first `bit_tick` of a bit period raises `ser_clk`, unless the clock is gated. The second `bit_tick` lowers it and starts the next bit. A frame is 64 bit periods, numbered 0 to 63. `ser_fsync` is 1 only during bit period 63, which is the period just before bit 0.
- R3: In bits 0 to 15, `ser_dout` carries the left playback sample, MSB first. In bits 16 to 31 it carries the right playback sample, MSB first. The output bit changes only on a falling tick. Playback samples are latched at the frame start, so changes to them during a frame have no effect on that frame.
- R4: With format 10, `ser_clk` stays low during bits 32 to 63, and `ser_fsync` still marks bit 63.
- R5: With format 00, the status field is sent as follows:
  - Bits 32 to 38 are 0.
  - Bit 39 is interrupt, bit 40 capture enable, bit 41 playback enable.
  - Bit 42 is the OR of left and right overrange.
  - Bits 43 to 63 are 0.
  - The flags are latched at the frame start.
- R6: With format 11, `ser_dout` sends the playback samples in bits 0 to 31. The left capture sample is taken from bits 32 to 47 and the right capture sample from bits 48 to 63.
- R7: `ser_din` is sampled on rising ticks, MSB first.
  - With formats 00, 01 and 10, the left capture slot is bits 0 to 15 and the right slot is bits 16 to 31.
  - A capture sample and its valid pulse appear one clock after the rising tick of the slot's last bit.
  - The valid pulse lasts one clock. At most one of the two valid pulses is high at a time.
  - A capture sample holds its value between pulses.
- R8: A change of `fmt_sel` during a frame does not affect that frame. The new format takes effect at the next frame start.
- R9: Format 01 behaves exactly as format 00.
- R10: Every bit that carries no sample or flag is sent as 0. This covers bits 32 to 63 with formats 10 and 11, and bits 32 to 63 outside the flag positions with formats 00 and 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Half-bit-period enable |
| fmt_sel | input | 2 | Frame format select |
| play_left | input | 16 | Left playback sample |
| play_right | input | 16 | Right playback sample |
| st_int | input | 1 | Interrupt status flag |
| st_cen | input | 1 | Capture enable flag |
| st_pen | input | 1 | Playback enable flag |
| st_ovr_left | input | 1 | Left overrange flag |
| st_ovr_right | input | 1 | Right overrange flag |
| ser_din | input | 1 | Serial capture data in |
| ser_clk | output | 1 | Serial bit clock |
| ser_fsync | output | 1 | Frame sync |
| ser_dout | output | 1 | Serial playback data out |
| cap_left | output | 16 | Left capture sample |
| cap_left_valid | output | 1 | Left capture valid pulse |
| cap_right | output | 16 | Right capture sample |
| cap_right_valid | output | 1 | Right capture valid pulse |

## Verification
The hardest situation to reach is an input change in the middle of a frame. Such a change must be ignored until the next frame start: a format switch that would gate the clock or move the capture slots, or new playback samples and flags. The stimulus re-randomises `fmt_sel`, the samples and the flags at random ticks inside every frame. It then applies the planned format and fresh values during bit 63 just before the falling tick, so that each frame checks both the latched values and the discarded ones. Directed frames add edge patterns (MSB-only and LSB-only samples, all ones, a single overrange side), and the format plan visits every code, including both transitions into and out of the gapped format.

// File: rtl/sap_pkg.sv
package sap_pkg;

    typedef enum logic [1:0] {
        FMT_ENH     = 2'b00,
        FMT_ENH_ALT = 2'b01,
        FMT_GAP     = 2'b10,
        FMT_SPLIT   = 2'b11
    } sap_fmt_e;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_FRONT = 2'd1,
        ST_BACK  = 2'd2
    } sap_state_e;

    // Position of the first flag inside the back half of an enhanced frame
    localparam int FLAG_LEAD_ZEROS = 7;
    localparam int FLAG_COUNT      = 4;

endpackage

// File: rtl/sap_timing.sv
module sap_timing
    import sap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bit_tick,
    input  sap_fmt_e                    fmt_in,
    output logic [$clog2(4*W)-1:0]      bit_idx,
    output sap_fmt_e                    fmt_cur,
    output logic                        rise_stb,
    output logic                        fall_stb,
    output logic                        frame_start,
    output logic                        sclk,
    output logic                        fsync
);

    localparam int FRAME = 4 * W;
    localparam int CW    = $clog2(FRAME);
    localparam logic [CW-1:0] LAST_BIT  = CW'(FRAME - 1);
    localparam logic [CW-1:0] FRONT_END = CW'(2 * W - 1);
    localparam logic [CW-1:0] BACK_END  = CW'(FRAME - 2);
    localparam logic [CW-1:0] HALF      = CW'(2 * W);

    sap_state_e     state, state_nx;
    logic           phase_hi;
    logic [CW-1:0]  bit_cnt;
    sap_fmt_e       fmt_q;
    logic           sclk_q;
    logic           clk_gated;

    assign rise_stb    = bit_tick & ~phase_hi;
    assign fall_stb    = bit_tick & phase_hi;
    assign frame_start = fall_stb && (state == ST_SYNC);
    assign clk_gated   = (fmt_q == FMT_GAP) && (bit_cnt >= HALF);

    // Next-state decision, evaluated only on falling ticks
    always_comb begin
        state_nx = state;
        if (fall_stb) begin
            unique case (state)
                ST_SYNC:  state_nx = ST_FRONT;
                ST_FRONT: if (bit_cnt == FRONT_END) state_nx = ST_BACK;
                ST_BACK:  if (bit_cnt == BACK_END)  state_nx = ST_SYNC;
                default:  state_nx = ST_SYNC;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SYNC;
        end else begin
            state <= state_nx;
        end
    end

    // Half-period phase, bit counter and frame format latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_hi <= 1'b0;
            bit_cnt  <= LAST_BIT;
            fmt_q    <= FMT_ENH;
        end else begin
            if (bit_tick) begin
                phase_hi <= ~phase_hi;
            end
            if (fall_stb) begin
                bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
            end
            if (frame_start) begin
                fmt_q <= fmt_in;
            end
        end
    end

    // Output process: serial clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else if (rise_stb) begin
            sclk_q <= ~clk_gated;
        end else if (fall_stb) begin
            sclk_q <= 1'b0;
        end
    end

    assign sclk    = sclk_q;
    assign fsync   = (state == ST_SYNC);
    assign bit_idx = bit_cnt;
    assign fmt_cur = fmt_q;

    // R4: no clock pulse in the back half of a gapped frame
    assert_gap_no_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q == FMT_GAP && bit_cnt >= HALF) |-> !sclk_q);

    // R8: format only moves at a frame start
    assert_fmt_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fmt_q) |-> $past(frame_start));

    // R2: clock is low right after a falling tick
    assert_clock_low_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fall_stb) |-> !sclk_q);

    // R2: sync is left only through the frame start
    assert_sync_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fsync) |-> $past(frame_start));

endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic                        fall_stb,
    input  logic [$clog2(4*W)-1:0]      bit_idx,
    input  sap_fmt_e                    fmt_in,
    input  logic [W-1:0]                play_left,
    input  logic [W-1:0]                play_right,
    input  logic                        st_int,
    input  logic                        st_cen,
    input  logic                        st_pen,
    input  logic                        st_ovr,
    output logic                        sdo
);

    localparam int FRAME = 4 * W;
    localparam int CW    = $clog2(FRAME);
    localparam int TAIL  = 2 * W - FLAG_LEAD_ZEROS - FLAG_COUNT;
    localparam logic [CW-1:0] QUIET_FROM = CW'(2 * W + FLAG_LEAD_ZEROS + FLAG_COUNT);

    logic [FRAME-1:0]  tx_sh;
    logic [2*W-1:0]    back_word;
    logic              with_flags;

    assign with_flags = (fmt_in == FMT_ENH) || (fmt_in == FMT_ENH_ALT);

    always_comb begin
        if (with_flags) begin
            back_word = {{FLAG_LEAD_ZEROS{1'b0}}, st_int, st_cen, st_pen, st_ovr, {TAIL{1'b0}}};
        end else begin
            back_word = '0;
        end
    end

    // Frame image loaded at frame start, shifted MSB first on falling ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (frame_start) begin
            tx_sh <= {play_left, play_right, back_word};
        end else if (fall_stb) begin
            tx_sh <= {tx_sh[FRAME-2:0], 1'b0};
        end
    end

    assign sdo = tx_sh[FRAME-1];

    // R3: the data line moves only after a falling tick
    assert_dout_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(fall_stb));

    // R10: nothing is sent after the flag field
    assert_tail_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx >= QUIET_FROM) |-> !sdo);

endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rise_stb,
    input  logic [$clog2(4*W)-1:0]      bit_idx,
    input  sap_fmt_e                    fmt_cur,
    input  logic                        sdin,
    output logic [W-1:0]                cap_left,
    output logic                        cap_left_valid,
    output logic [W-1:0]                cap_right,
    output logic                        cap_right_valid
);

    localparam int FRAME = 4 * W;
    localparam int CW    = $clog2(FRAME);
    localparam logic [CW-1:0] HALF      = CW'(2 * W);
    localparam logic [CW-1:0] LEFT_END  = CW'(W - 1);
    localparam logic [CW-1:0] RIGHT_END = CW'(2 * W - 1);

    logic [CW-1:0]  slot_base;
    logic [CW-1:0]  rel_bit;
    logic           in_slot;
    logic [W-1:0]   rx_sh;
    logic [W-1:0]   rx_next;

    assign slot_base = (fmt_cur == FMT_SPLIT) ? HALF : '0;
    assign rel_bit   = bit_idx - slot_base;
    assign in_slot   = rel_bit < HALF;
    assign rx_next   = {rx_sh[W-2:0], sdin};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh           <= '0;
            cap_left        <= '0;
            cap_right       <= '0;
            cap_left_valid  <= 1'b0;
            cap_right_valid <= 1'b0;
        end else begin
            cap_left_valid  <= 1'b0;
            cap_right_valid <= 1'b0;
            if (rise_stb && in_slot) begin
                rx_sh <= rx_next;
                if (rel_bit == LEFT_END) begin
                    cap_left       <= rx_next;
                    cap_left_valid <= 1'b1;
                end
                if (rel_bit == RIGHT_END) begin
                    cap_right       <= rx_next;
                    cap_right_valid <= 1'b1;
                end
            end
        end
    end

    // R7: only one capture channel reported at a time
    assert_one_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_left_valid, cap_right_valid}));

    // R7: valid pulses last one clock
    assert_left_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_left_valid |=> !cap_left_valid);

    // R7: a sample only changes alongside its valid pulse
    assert_left_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_left) |-> cap_left_valid);

    assert_right_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_right) |-> cap_right_valid);

endmodule

// File: rtl/sap_framer.sv
module sap_framer
    import sap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic [1:0]    fmt_sel,
    input  logic [W-1:0]  play_left,
    input  logic [W-1:0]  play_right,
    input  logic          st_int,
    input  logic          st_cen,
    input  logic          st_pen,
    input  logic          st_ovr_left,
    input  logic          st_ovr_right,
    input  logic          ser_din,
    output logic          ser_clk,
    output logic          ser_fsync,
    output logic          ser_dout,
    output logic [W-1:0]  cap_left,
    output logic          cap_left_valid,
    output logic [W-1:0]  cap_right,
    output logic          cap_right_valid
);

    localparam int CW = $clog2(4 * W);

    logic [CW-1:0]  bit_idx;
    sap_fmt_e       fmt_cur;
    sap_fmt_e       fmt_in;
    logic           rise_stb;
    logic           fall_stb;
    logic           frame_start;

    assign fmt_in = sap_fmt_e'(fmt_sel);

    sap_timing #(.W(W)) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .fmt_in      (fmt_in),
        .bit_idx     (bit_idx),
        .fmt_cur     (fmt_cur),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .frame_start (frame_start),
        .sclk        (ser_clk),
        .fsync       (ser_fsync)
    );

    sap_tx #(.W(W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .fall_stb    (fall_stb),
        .bit_idx     (bit_idx),
        .fmt_in      (fmt_in),
        .play_left   (play_left),
        .play_right  (play_right),
        .st_int      (st_int),
        .st_cen      (st_cen),
        .st_pen      (st_pen),
        .st_ovr      (st_ovr_left | st_ovr_right),
        .sdo         (ser_dout)
    );

    sap_rx #(.W(W)) u_rx (
        .clk             (clk),
        .rst_n           (rst_n),
        .rise_stb        (rise_stb),
        .bit_idx         (bit_idx),
        .fmt_cur         (fmt_cur),
        .sdin            (ser_din),
        .cap_left        (cap_left),
        .cap_left_valid  (cap_left_valid),
        .cap_right       (cap_right),
        .cap_right_valid (cap_right_valid)
    );

endmodule

// File: tb/sap_framer_test.sv
module sap_framer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_tick;
    logic [1:0]  fmt_sel;
    logic [15:0] play_left, play_right;
    logic        st_int, st_cen, st_pen, st_ovr_left, st_ovr_right;
    logic        ser_din;
    logic        ser_clk, ser_fsync, ser_dout;
    logic [15:0] cap_left, cap_right;
    logic        cap_left_valid, cap_right_valid;

    always #10 clk = ~clk;

    sap_framer uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fmt_sel(fmt_sel),
        .play_left(play_left), .play_right(play_right),
        .st_int(st_int), .st_cen(st_cen), .st_pen(st_pen),
        .st_ovr_left(st_ovr_left), .st_ovr_right(st_ovr_right),
        .ser_din(ser_din), .ser_clk(ser_clk), .ser_fsync(ser_fsync), .ser_dout(ser_dout),
        .cap_left(cap_left), .cap_left_valid(cap_left_valid),
        .cap_right(cap_right), .cap_right_valid(cap_right_valid)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    int          eph, ebit, efmt;
    logic [15:0] el, er, ecl, ecr;
    logic [3:0]  est;
    logic [63:0] dinb;
    logic [15:0] nx_l, nx_r;
    logic [4:0]  nx_st;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (bit %0d fmt %0d)", tag, act, exp, ebit, efmt);
        end
    endtask

    function automatic logic exp_dout(int b, int f, logic [15:0] l, logic [15:0] r, logic [3:0] s);
        if (b < 16) return l[15-b];
        if (b < 32) return r[31-b];
        if (f < 2 && b >= 39 && b <= 42) return s[42-b];
        return 1'b0;
    endfunction

    function automatic string dout_tag(int b, int f);
        if (b < 32) return "R3";
        if (f == 1) return "R9";
        if (f == 0 && b >= 39 && b <= 42) return "R5";
        if (f == 3) return "R6";
        return "R10";
    endfunction

    function automatic logic [15:0] slot_val(logic [63:0] d, int base);
        logic [15:0] v;
        for (int k = 0; k < 16; k++) v[15-k] = d[base+k];
        return v;
    endfunction

    task automatic tick_once(input int plan_fmt);
        logic din;
        bit   gated, lv, rv;
        int   base, rel;
        string ctag;
        if (eph == 1 && ebit == 63) begin
            fmt_sel    = plan_fmt[1:0];
            play_left  = nx_l;
            play_right = nx_r;
            {st_int, st_cen, st_pen, st_ovr_left, st_ovr_right} = nx_st;
        end else if ($urandom % 6 == 0) begin
            fmt_sel    = 2'($urandom);
            play_left  = 16'($urandom);
            play_right = 16'($urandom);
            {st_int, st_cen, st_pen, st_ovr_left, st_ovr_right} = 5'($urandom);
        end
        din = 1'($urandom);
        ser_din = din;
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        if (eph == 0) begin
            eph = 1;
            dinb[ebit] = din;
            gated = (efmt == 2) && (ebit >= 32);
            ctag = (int'(fmt_sel) != efmt) ? "R8" : (gated ? "R4" : "R2");
            check(ser_clk == !gated, ctag, 32'(ser_clk), 32'(!gated));
            base = (efmt == 3) ? 32 : 0;
            rel  = ebit - base;
            lv = (rel == 15);
            rv = (rel == 31);
            if (lv) ecl = slot_val(dinb, base);
            if (rv) ecr = slot_val(dinb, base + 16);
            ctag = (efmt == 3) ? "R6" : "R7";
            check(cap_left_valid == lv, ctag, 32'(cap_left_valid), 32'(lv));
            check(cap_right_valid == rv, ctag, 32'(cap_right_valid), 32'(rv));
            check(cap_left == ecl, ctag, 32'(cap_left), 32'(ecl));
            check(cap_right == ecr, ctag, 32'(cap_right), 32'(ecr));
        end else begin
            eph = 0;
            ebit = (ebit + 1) % 64;
            if (ebit == 0) begin
                efmt = int'(fmt_sel);
                el = play_left;
                er = play_right;
                est = {st_int, st_cen, st_pen, st_ovr_left | st_ovr_right};
            end
            check(ser_clk == 1'b0, "R2", 32'(ser_clk), 32'd0);
        end
        check(ser_fsync == (ebit == 63), (efmt == 2) ? "R4" : "R2", 32'(ser_fsync), 32'(ebit == 63));
        check(ser_dout == exp_dout(ebit, efmt, el, er, est), dout_tag(ebit, efmt),
              32'(ser_dout), 32'(exp_dout(ebit, efmt, el, er, est)));
    endtask

    initial begin
        int plan [12] = '{0, 2, 3, 1, 0, 2, 3, 0, 1, 3, 2, 0};
        void'($urandom(32'hC0DE5A11));
        rst_n = 1'b0; bit_tick = 1'b0; fmt_sel = 2'b00;
        play_left = '0; play_right = '0;
        {st_int, st_cen, st_pen, st_ovr_left, st_ovr_right} = '0;
        ser_din = 1'b0;
        eph = 0; ebit = 63; efmt = 0; el = '0; er = '0; est = '0;
        ecl = '0; ecr = '0; dinb = '0;
        repeat (4) @(negedge clk);
        check(ser_clk == 0 && ser_fsync == 1 && ser_dout == 0, "R1",
              {29'd0, ser_clk, ser_fsync, ser_dout}, 32'b010);
        rst_n = 1'b1;
        @(negedge clk);
        check(ser_clk == 0 && ser_fsync == 1 && ser_dout == 0, "R1",
              {29'd0, ser_clk, ser_fsync, ser_dout}, 32'b010);
        check(cap_left == 0 && cap_right == 0, "R1", {cap_left, cap_right}, 32'd0);
        check(!cap_left_valid && !cap_right_valid, "R1",
              {30'd0, cap_left_valid, cap_right_valid}, 32'd0);
        for (int fi = 0; fi < 12; fi++) begin
            case (fi)
                0: begin nx_l = 16'h8001; nx_r = 16'h7FFE; nx_st = 5'b10110; end
                1: begin nx_l = 16'hFFFF; nx_r = 16'h0000; nx_st = 5'b11111; end
                2: begin nx_l = 16'h0001; nx_r = 16'h8000; nx_st = 5'b00001; end
                3: begin nx_l = 16'hA5A5; nx_r = 16'h5A5A; nx_st = 5'b01001; end
                default: begin nx_l = 16'($urandom); nx_r = 16'($urandom); nx_st = 5'($urandom); end
            endcase
            for (int t = 0; t < 128; t++) tick_once(plan[fi]);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule